// File: doc/BRIEF.md
# Speculative Reorder Buffer with In-Order Retirement

This block sits between instruction issue and architectural state in an out-of-order core. It holds every in-flight instruction in a circular buffer of `DEPTH` slots, seven by default. When an instruction issues it takes the slot at the tail. The slot number comes back on `iss_tag` and is used as the result tag. Execution units later return results by tag, in any order. A completed result is held speculatively, and operand lookups by tag can read it until the instruction retires.

Retirement is strictly in order. Each cycle, the oldest slot retires if its result is present. Depending on its kind, it produces a register write, a store, nothing (a branch that was predicted correctly), or a squash. A fault reported by an instruction is only noted in its slot. It takes effect when that slot becomes the oldest. At that point, and also when a branch marked as mispredicted becomes the oldest, every slot is discarded and a pulse is raised. Slot numbering then restarts at zero.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset, `iss_ready` is 1, `iss_tag` is 0, and `wr_valid`, `st_valid`, `exc_valid`, `redirect` and `lk_ready` are all 0.
- R2: An instruction is accepted on a cycle with `iss_valid` and `iss_ready` both high, and it receives the tag shown on `iss_tag`. Successive accepted instructions receive tags in ascending order, wrapping from `DEPTH-1` to 0. After `DEPTH` accepted instructions with no retirement, `iss_ready` is 0 and further issue attempts are refused.
- R3: A completion (`cmp_valid` with `cmp_tag`) to an allocated slot stores `cmp_value` and marks the slot done. A lookup presented on `lk_tag` is answered one cycle later: `lk_ready` is 1 with the stored value if that slot was allocated and done, and `lk_ready` is 0 otherwise.
- R4: Only the oldest slot may retire, and only once it is done. Younger slots that are already done wait, producing no retirement output.
- R5: Retirement results appear on the registered outputs one cycle after the retiring cycle, and at most one retirement output is high in any cycle. A retiring slot of kind 0 (register result) pulses `wr_valid` with its destination and value. A retiring slot of kind 1 (store) pulses `st_valid` with its value and leaves `wr_valid` low.
- R6: A fault flag given with a completion raises nothing while the slot is younger than the oldest. When the slot becomes the oldest and retires, the block pulses `exc_valid` with `exc_tag` equal to the slot number, suppresses the write, and empties the buffer, so that `iss_tag` returns to 0 and `iss_ready` to 1.
- R7: A retiring slot of kind 2 (branch) that was completed with `cmp_mispred` set pulses `redirect` and discards all younger slots, so none of them ever writes. A retiring branch without the flag produces no output, and the next slot retires normally.
- R8: A completion whose tag names a slot that is not allocated changes nothing. A later allocation of that slot starts not done.
- R9: When an issue is accepted in the same cycle as a normal retirement, occupancy is unchanged: the buffer becomes full only after one further issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Kind: 0 register result, 1 store, 2 branch |
| iss_dest | input | DEST_W | Destination register of the issuing instruction |
| iss_ready | output | 1 | A free slot exists |
| iss_tag | output | IDX_W | Slot number given to the next accepted issue |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_tag | input | IDX_W | Slot number being completed |
| cmp_value | input | DATA_W | Result value |
| cmp_exc | input | 1 | The instruction raised a fault |
| cmp_mispred | input | 1 | The branch was mispredicted |
| lk_tag | input | IDX_W | Operand lookup slot number |
| lk_ready | output | 1 | Looked-up slot holds a finished result (one cycle later) |
| lk_value | output | DATA_W | Looked-up value |
| wr_valid | output | 1 | Register write from retirement |
| wr_dest | output | DEST_W | Register written |
| wr_value | output | DATA_W | Value written |
| st_valid | output | 1 | Store released by retirement |
| st_value | output | DATA_W | Store data |
| exc_valid | output | 1 | Fault taken at retirement |
| exc_tag | output | IDX_W | Slot that faulted |
| redirect | output | 1 | Mispredicted branch retired, buffer emptied |

## Verification
On every cycle, the bound checker confirms several things. Occupancy never exceeds the slot count. The tag offered is always a legal slot. An accepted issue raises occupancy by one, unless a retirement coincides with it, in which case occupancy holds. At most one retirement output pulses in any cycle. Any squash pulse finds the buffer empty.

The orderings need the bench's scenarios. These include retirement order against a reversed completion order, the store/register split, faults deferred past younger slots, squashed writes after a mispredicted branch, and ignored completions to free slots.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 7,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] occ
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      case ({push, pop})
        2'b10:   occ <= occ + CNT_W'(1);
        2'b01:   occ <= occ - CNT_W'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH  = 7,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  parameter int DEST_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              cmp_en,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_exc,
  input  logic              cmp_mis,
  input  logic              free_en,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              head_busy,
  output logic              head_done,
  output logic              head_exc,
  output logic              head_mis,
  output logic [1:0]        head_kind,
  output logic [DEST_W-1:0] head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_value
);
  logic [DEPTH-1:0]  busy_q, done_q, exc_q, mis_q, cmp_hit;
  logic [1:0]        kind_q [DEPTH];
  logic [DEST_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] val_mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              busy_r, done_r, exc_r, mis_r;
    logic [1:0]        kind_r;
    logic [DEST_W-1:0] dest_r;

    assign cmp_hit[g] = cmp_en && (cmp_idx == IDX_W'(g)) && busy_r;

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        busy_r <= 1'b0;
        done_r <= 1'b0;
        exc_r  <= 1'b0;
        mis_r  <= 1'b0;
        kind_r <= '0;
        dest_r <= '0;
      end else if (alloc_en && alloc_idx == IDX_W'(g)) begin
        busy_r <= 1'b1;
        done_r <= 1'b0;
        exc_r  <= 1'b0;
        mis_r  <= 1'b0;
        kind_r <= alloc_kind;
        dest_r <= alloc_dest;
      end else begin
        if (cmp_hit[g]) begin
          done_r <= 1'b1;
          exc_r  <= cmp_exc;
          mis_r  <= cmp_mis;
        end
        if (free_en && free_idx == IDX_W'(g)) begin
          busy_r <= 1'b0;
          done_r <= 1'b0;
        end
      end
    end

    assign busy_q[g] = busy_r;
    assign done_q[g] = done_r;
    assign exc_q[g]  = exc_r;
    assign mis_q[g]  = mis_r;
    assign kind_q[g] = kind_r;
    assign dest_q[g] = dest_r;
  end

  // value storage: one write port, no reset, suited to LUT RAM
  always_ff @(posedge clk) begin
    if ((|cmp_hit) && !flush) val_mem[cmp_idx] <= cmp_value;
  end

  always_comb begin
    head_busy  = 1'b0;
    head_done  = 1'b0;
    head_exc   = 1'b0;
    head_mis   = 1'b0;
    head_kind  = '0;
    head_dest  = '0;
    head_value = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (head_idx == IDX_W'(i)) begin
        head_busy  = busy_q[i];
        head_done  = done_q[i];
        head_exc   = exc_q[i];
        head_mis   = mis_q[i];
        head_kind  = kind_q[i];
        head_dest  = dest_q[i];
        head_value = val_mem[i];
      end
    end
  end

  always_comb begin
    lk_hit   = 1'b0;
    lk_value = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_idx == IDX_W'(i)) begin
        lk_hit   = busy_q[i] && done_q[i];
        lk_value = val_mem[i];
      end
    end
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  parameter int DEST_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [1:0]        head_kind,
  input  logic              head_exc,
  input  logic              head_mis,
  input  logic [DEST_W-1:0] head_dest,
  input  logic [DATA_W-1:0] head_value,
  input  logic [IDX_W-1:0]  head_idx,
  output logic              wr_valid,
  output logic [DEST_W-1:0] wr_dest,
  output logic [DATA_W-1:0] wr_value,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_value,
  output logic              exc_valid,
  output logic [IDX_W-1:0]  exc_tag,
  output logic              redirect
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid  <= 1'b0;
      wr_dest   <= '0;
      wr_value  <= '0;
      st_valid  <= 1'b0;
      st_value  <= '0;
      exc_valid <= 1'b0;
      exc_tag   <= '0;
      redirect  <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      st_valid  <= 1'b0;
      exc_valid <= 1'b0;
      redirect  <= 1'b0;
      if (commit) begin
        if (head_exc) begin
          exc_valid <= 1'b1;
          exc_tag   <= head_idx;
        end else begin
          case (rob_kind_e'(head_kind))
            KIND_BRANCH: redirect <= head_mis;
            KIND_STORE: begin
              st_valid <= 1'b1;
              st_value <= head_value;
            end
            default: begin
              wr_valid <= 1'b1;
              wr_dest  <= head_dest;
              wr_value <= head_value;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 7,
  parameter int DATA_W = 32,
  parameter int DEST_W = 5,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [1:0]        iss_kind,
  input  logic [DEST_W-1:0] iss_dest,
  output logic              iss_ready,
  output logic [IDX_W-1:0]  iss_tag,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_exc,
  input  logic              cmp_mispred,
  input  logic [IDX_W-1:0]  lk_tag,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_value,
  output logic              wr_valid,
  output logic [DEST_W-1:0] wr_dest,
  output logic [DATA_W-1:0] wr_value,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_value,
  output logic              exc_valid,
  output logic [IDX_W-1:0]  exc_tag,
  output logic              redirect
);
  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  occ;
  logic              push, commit_now, flush_now;
  logic              h_busy, h_done, h_exc, h_mis;
  logic [1:0]        h_kind;
  logic [DEST_W-1:0] h_dest;
  logic [DATA_W-1:0] h_value;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_raw;

  assign iss_ready  = (occ != CNT_W'(DEPTH));
  assign iss_tag    = tail;
  assign commit_now = (occ != '0) && h_busy && h_done;
  assign flush_now  = commit_now &&
                      (h_exc || (rob_kind_e'(h_kind) == KIND_BRANCH && h_mis));
  assign push       = iss_valid && iss_ready && !flush_now;

  rob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(commit_now), .flush(flush_now),
    .head(head), .tail(tail), .occ(occ)
  );

  rob_entries #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_entries (
    .clk(clk), .rst(rst), .flush(flush_now),
    .alloc_en(push), .alloc_idx(tail), .alloc_kind(iss_kind), .alloc_dest(iss_dest),
    .cmp_en(cmp_valid), .cmp_idx(cmp_tag), .cmp_value(cmp_value),
    .cmp_exc(cmp_exc), .cmp_mis(cmp_mispred),
    .free_en(commit_now), .free_idx(head),
    .head_idx(head), .lk_idx(lk_tag),
    .head_busy(h_busy), .head_done(h_done), .head_exc(h_exc), .head_mis(h_mis),
    .head_kind(h_kind), .head_dest(h_dest), .head_value(h_value),
    .lk_hit(lk_hit), .lk_value(lk_raw)
  );

  rob_retire #(.IDX_W(IDX_W), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_retire (
    .clk(clk), .rst(rst), .commit(commit_now),
    .head_kind(h_kind), .head_exc(h_exc), .head_mis(h_mis),
    .head_dest(h_dest), .head_value(h_value), .head_idx(head),
    .wr_valid(wr_valid), .wr_dest(wr_dest), .wr_value(wr_value),
    .st_valid(st_valid), .st_value(st_value),
    .exc_valid(exc_valid), .exc_tag(exc_tag), .redirect(redirect)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_ready <= 1'b0;
      lk_value <= '0;
    end else begin
      lk_ready <= lk_hit;
      lk_value <= lk_hit ? lk_raw : '0;
    end
  end
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH = 7,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [IDX_W-1:0] iss_tag,
  input logic [CNT_W-1:0] occ,
  input logic             commit_now,
  input logic             flush_now,
  input logic             wr_valid,
  input logic             st_valid,
  input logic             exc_valid,
  input logic             redirect
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH); // R2
  AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    int'(iss_tag) < DEPTH); // R2
  AST_ISSUE_GROWS: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready && !commit_now) |=> (occ == $past(occ) + CNT_W'(1))); // R2
  AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready && commit_now && !flush_now) |=> $stable(occ)); // R9
  AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_valid, st_valid, exc_valid, redirect})); // R5
  AST_SQUASH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (exc_valid || redirect) |-> (occ == '0)); // R6
endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_tag(iss_tag), .occ(occ), .commit_now(commit_now), .flush_now(flush_now),
  .wr_valid(wr_valid), .st_valid(st_valid), .exc_valid(exc_valid),
  .redirect(redirect)
);

// File: tb/rob_core_test.sv
`timescale 1ns/1ps
module rob_core_test;
  localparam int DEPTH = 7;
  localparam int DATA_W = 32;
  localparam int DEST_W = 5;
  localparam int IDX_W = 3;
  localparam int NVEC = 5;
  localparam logic [DEST_W-1:0] T_DEST [NVEC] = '{5'd3, 5'd17, 5'd8, 5'd31, 5'd1};
  localparam logic [DATA_W-1:0] T_VAL  [NVEC] =
    '{32'h1111_0001, 32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001};

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 0; logic [1:0] iss_kind = 0; logic [DEST_W-1:0] iss_dest = 0;
  logic iss_ready; logic [IDX_W-1:0] iss_tag;
  logic cmp_valid = 0; logic [IDX_W-1:0] cmp_tag = 0; logic [DATA_W-1:0] cmp_value = 0;
  logic cmp_exc = 0, cmp_mispred = 0;
  logic [IDX_W-1:0] lk_tag = 0; logic lk_ready; logic [DATA_W-1:0] lk_value;
  logic wr_valid; logic [DEST_W-1:0] wr_dest; logic [DATA_W-1:0] wr_value;
  logic st_valid; logic [DATA_W-1:0] st_value;
  logic exc_valid; logic [IDX_W-1:0] exc_tag; logic redirect;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dest(iss_dest),
    .iss_ready(iss_ready), .iss_tag(iss_tag), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_value(cmp_value), .cmp_exc(cmp_exc), .cmp_mispred(cmp_mispred),
    .lk_tag(lk_tag), .lk_ready(lk_ready), .lk_value(lk_value),
    .wr_valid(wr_valid), .wr_dest(wr_dest), .wr_value(wr_value),
    .st_valid(st_valid), .st_value(st_value), .exc_valid(exc_valid),
    .exc_tag(exc_tag), .redirect(redirect)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic [DEST_W-1:0] dest);
    iss_valid = 1; iss_kind = kind; iss_dest = dest;
    tick();
    iss_valid = 0;
  endtask

  task automatic complete(input logic [IDX_W-1:0] tag, input logic [DATA_W-1:0] val,
                          input logic exc, input logic mis);
    cmp_valid = 1; cmp_tag = tag; cmp_value = val; cmp_exc = exc; cmp_mispred = mis;
    tick();
    cmp_valid = 0; cmp_exc = 0; cmp_mispred = 0;
  endtask

  function automatic logic [31:0] retire_bits();
    return {28'd0, wr_valid, st_valid, exc_valid, redirect};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 0;
    // R1 reset state
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 iss_tag", iss_tag, 0);
    chk("R1 retire outputs", retire_bits(), 0);
    chk("R1 lk_ready", lk_ready, 0);

    // vector table: issue, complete in reverse, retire in issue order
    for (int i = 0; i < NVEC; i++) begin
      chk("R2 ascending tag", iss_tag, i);
      issue(2'd0, T_DEST[i]);
    end
    lk_tag = 3'd2;
    tick();
    chk("R3 lookup before completion", lk_ready, 0);
    for (int i = NVEC - 1; i >= 0; i--) begin
      complete(IDX_W'(i), T_VAL[i], 0, 0);
      if (i > 0) chk("R4 younger done waits", retire_bits(), 0);
    end
    chk("R3 lookup ready", lk_ready, 1);
    chk("R3 lookup value", lk_value, T_VAL[2]);
    for (int i = 0; i < NVEC; i++) begin
      tick();
      chk("R5 wr_valid in order", wr_valid, 1);
      chk("R5 wr_dest in order", wr_dest, T_DEST[i]);
      chk("R4 wr_value in order", wr_value, T_VAL[i]);
    end
    tick();
    chk("R4 retirement stops", retire_bits(), 0);
    chk("R2 tail after five", iss_tag, 5);

    // fill and wrap
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 wrapping tag", iss_tag, (5 + i) % DEPTH);
      issue((i == 0) ? 2'd1 : 2'd0, DEST_W'(i));
    end
    chk("R2 full refuses", iss_ready, 0);
    issue(2'd0, 5'd20);
    chk("R2 refused issue keeps tag", iss_tag, 5);
    chk("R2 still full", iss_ready, 0);
    complete(3'd6, 32'h66, 0, 0);
    chk("R4 non-head done waits", retire_bits(), 0);
    complete(3'd5, 32'hAAAA, 0, 0);
    tick();
    chk("R5 store pulse", st_valid, 1);
    chk("R5 store value", st_value, 32'hAAAA);
    chk("R5 store no write", wr_valid, 0);
    chk("R2 slot freed", iss_ready, 1);
    issue(2'd0, 5'd9);
    chk("R9 retire with issue", wr_value, 32'h66);
    chk("R9 tag advanced", iss_tag, 6);
    chk("R9 not yet full", iss_ready, 1);
    issue(2'd0, 5'd10);
    chk("R9 full after one more", iss_ready, 0);

    // deferred fault: head is slot 0, fault on slot 1
    complete(3'd1, 32'h1, 1, 0);
    chk("R6 fault deferred", exc_valid, 0);
    complete(3'd0, 32'h0A0A, 0, 0);
    tick();
    chk("R6 older slot retires first", wr_value, 32'h0A0A);
    chk("R6 no fault yet", exc_valid, 0);
    tick();
    chk("R6 fault pulse", exc_valid, 1);
    chk("R6 fault slot", exc_tag, 1);
    chk("R6 no write on fault", wr_valid, 0);
    chk("R6 tag restarts", iss_tag, 0);
    chk("R6 ready after squash", iss_ready, 1);
    tick();
    chk("R6 nothing after squash", retire_bits(), 0);

    // mispredicted branch
    issue(2'd2, 5'd0);
    issue(2'd0, 5'd7);
    complete(3'd1, 32'h77, 0, 0);
    complete(3'd0, 32'h0, 0, 1);
    tick();
    chk("R7 redirect pulse", redirect, 1);
    chk("R7 no write at redirect", wr_valid, 0);
    chk("R7 tag restarts", iss_tag, 0);
    tick();
    chk("R7 younger slot squashed", retire_bits(), 0);

    // correctly predicted branch
    issue(2'd2, 5'd0);
    issue(2'd0, 5'd12);
    complete(3'd0, 32'h0, 0, 0);
    complete(3'd1, 32'hC0DE, 0, 0);
    chk("R7 good branch silent", retire_bits(), 0);
    tick();
    chk("R7 next retires", wr_valid, 1);
    chk("R7 next dest", wr_dest, 12);
    chk("R7 next value", wr_value, 32'hC0DE);

    // completion to a free slot (head and tail now at 2)
    issue(2'd0, 5'd2);
    complete(3'd4, 32'h55, 0, 0);
    chk("R8 stray completion no output", retire_bits(), 0);
    issue(2'd0, 5'd3);
    issue(2'd0, 5'd4);
    lk_tag = 3'd4;
    tick();
    chk("R8 slot starts not done", lk_ready, 0);
    chk("R8 nothing retired", retire_bits(), 0);
    lk_tag = 3'd2;
    complete(3'd2, 32'h22, 0, 0);
    chk("R3 lookup same edge as completion", lk_ready, 0);
    tick();
    chk("R3 lookup after completion", lk_ready, 1);
    chk("R3 lookup value after completion", lk_value, 32'h22);
    chk("R5 slot 2 retires", wr_value, 32'h22);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule